// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial two-wire slave that keeps a small bank of 8-bit configuration registers and drives them onto a parallel bus. The system clock samples both serial lines. It recognises one 8-bit write address (0xD2) and one read address (0xD3). The host writes with a block-write transfer. The first two bytes after the address stand in for a command code and a byte count; the slave acknowledges both and discards their values. The data bytes that follow fill register 0, then register 1, and so on upward. The host may end the transfer with a stop after any whole byte.

A block read returns a byte count of 6 and then the registers in ascending order. The serial data line is open-drain. The block reports only whether it pulls the line low, and the surrounding pad logic does the pulling. Register 0 also carries mode fields that are decoded onto dedicated outputs: the frequency source select, a 5-bit frequency code, spread enable and a global tristate request. Both lines pass through a synchroniser and a two-sample agreement filter before the slave looks for edges, start conditions or stop conditions.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges the 8-bit address bytes 0xD2 (write) and 0xD3 (read). It drives SDA low during the ninth clock of the address byte.
- R2: In a write, the slave acknowledges the two bytes after the address and discards their values. Each later data byte is acknowledged and stored, the first in register 0 and each next one in the next register up.
- R3: A stop after any complete byte ends the write. Registers already written keep their new values, and registers not reached keep their old values.
- R4: In a read, the slave sends the count value 6 first and then registers 0 to 5, most significant bit first. A NACK from the host on any byte ends the read.
- R5: Reset loads 0x00 into register 0 and 0xFF into registers 1 to 5.
- R6: An address byte other than 0xD2 or 0xD3 is not acknowledged (SDA stays high on the ninth clock), and the registers do not change.
- R7: Data bytes beyond the sixth are acknowledged and discarded. A read that continues past register 5 returns the reserved value 0x06.
- R8: Register 0 is decoded as follows. Bit 3 drives freqFromReg. freqCode is {bit 2, bits 7:4}, with bit 2 as its MSB. Bit 1 drives spreadEn. Bit 0 drives outTristate.
- R9: A pulse of one clock period on SDA while SCL is high is ignored: it is taken as neither a start nor a stop, and the transfer around it completes normally.
- R10: Register k appears on cfgBus bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| cfgBus | output | 48 | All registers side by side, register 0 in the low byte |
| freqFromReg | output | 1 | Frequency source select (register 0 bit 3) |
| freqCode | output | 5 | Register-selected frequency code |
| spreadEn | output | 1 | Spread enable (register 0 bit 1) |
| outTristate | output | 1 | Global output tristate request (register 0 bit 0) |

## Verification
A wrong byte index in the controller shifts every later data byte into the neighbouring register. This shows on cfgBus right after the stop, and it shows again in the read-back of that transfer. A wrong bit counter or a wrong state after an acknowledge breaks bit alignment. The ninth-clock acknowledge of the next byte then samples the wrong level, so the fault appears within a single byte time. A missing or leaky filter turns the injected SDA pulse into a false start or stop. That aborts the write, and the cfgBus check after the transfer fails.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACKW,
    ST_SEND,
    ST_ACKR
  } busState_t;

  // Strobes from the protocol controller to the register datapath.
  typedef struct packed {
    logic             shiftIn;
    logic             loadTx;
    logic             shiftTx;
    logic             wrEn;
    logic [IDX_W-1:0] idx;
  } strobe_t;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] cleanOut
);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    // pipe[0], pipe[1]: synchroniser; pipe[2]: previous synchronised sample
    logic [2:0] pipe;
    logic       held;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe <= '1;
        held <= 1'b1;
      end else begin
        pipe <= {pipe[1:0], rawIn[g]};
        if (pipe[2] == pipe[1]) held <= pipe[1];
      end
    end

    assign cleanOut[g] = held;
  end

endmodule

// File: rtl/smb_cfg_ctrl.sv
module smb_cfg_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    stb,
  output logic       sdaOe,
  output busState_t  busState
);

  localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_MAX    = '1;
  localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(2);

  logic             sclQ, sdaQ;
  logic [3:0]       bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic             isRead, addrPhase;
  logic             sclRise, sclFall, startCond, stopCond, byteEnd, addrHit;
  logic [IDX_W-1:0] idxNext;

  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startCond = sclF & sclQ & sdaQ & ~sdaF;
  assign stopCond  = sclF & sclQ & ~sdaQ & sdaF;
  assign byteEnd   = (busState == ST_RECV) && sclFall && (bitCnt == 4'd8);
  assign addrHit   = (rxByte == WR_ADDR) || (rxByte == RD_ADDR);
  assign idxNext   = (byteIdx == IDX_MAX) ? byteIdx : byteIdx + IDX_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      busState  <= ST_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      isRead    <= 1'b0;
      addrPhase <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (stopCond) begin
        busState <= ST_IDLE;
      end else if (startCond) begin
        busState  <= ST_RECV;
        bitCnt    <= '0;
        byteIdx   <= '0;
        isRead    <= 1'b0;
        addrPhase <= 1'b1;
      end else begin
        unique case (busState)
          ST_RECV: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (byteEnd) begin
              if (addrPhase) begin
                if (addrHit) begin
                  busState  <= ST_ACKW;
                  isRead    <= (rxByte == RD_ADDR);
                  addrPhase <= 1'b0;
                end else begin
                  busState <= ST_IDLE;
                end
              end else begin
                busState <= ST_ACKW;
                byteIdx  <= idxNext;
              end
            end
          end
          ST_ACKW: begin
            if (sclFall) begin
              bitCnt   <= '0;
              busState <= isRead ? ST_SEND : ST_RECV;
            end
          end
          ST_SEND: begin
            if (sclFall) begin
              bitCnt <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) busState <= ST_ACKR;
            end
          end
          ST_ACKR: begin
            if (sclRise && sdaF) begin
              busState <= ST_IDLE;
            end else if (sclFall) begin
              busState <= ST_SEND;
              bitCnt   <= '0;
              byteIdx  <= idxNext;
            end
          end
          default: busState <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.shiftIn = (busState == ST_RECV) && sclRise;
    stb.shiftTx = (busState == ST_SEND) && sclFall;
    if ((busState == ST_ACKW) && sclFall && isRead) begin
      stb.loadTx = 1'b1;
      stb.idx    = byteIdx;
    end
    if ((busState == ST_ACKR) && sclFall && !sdaF) begin
      stb.loadTx = 1'b1;
      stb.idx    = idxNext;
    end
    if (byteEnd && !addrPhase && !isRead && (byteIdx >= FIRST_DATA)) begin
      stb.wrEn = 1'b1;
      stb.idx  = byteIdx - FIRST_DATA;
    end
  end

  always_comb begin
    unique case (busState)
      ST_ACKW: sdaOe = 1'b1;
      ST_SEND: sdaOe = ~txBit;
      default: sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/smb_cfg_dpath.sv
module smb_cfg_dpath
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF,
  parameter logic [7:0] RSVD_VAL  = 8'h06
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaF,
  input  strobe_t               stb,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] cfgBus
);

  localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];
  logic [7:0] txShift;
  logic [7:0] txNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= (i == 0) ? REG0_INIT : REGN_INIT;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (stb.wrEn && (stb.idx == IDX_W'(i))) regs[i] <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '1;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaF};
      if (stb.loadTx)       txShift <= txNext;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  // Read index 0 is the count, index k is register k-1, beyond is reserved.
  always_comb begin
    txNext = RSVD_VAL;
    if (stb.idx == '0) txNext = COUNT_VAL;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (stb.idx == IDX_W'(i + 1)) txNext = regs[i];
    end
  end

  assign txBit = txShift[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBus
    assign cfgBus[8*g +: 8] = regs[g];
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter logic [7:0] RD_ADDR   = 8'hD3,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF,
  parameter logic [7:0] RSVD_VAL  = 8'h06
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] cfgBus,
  output logic                  freqFromReg,
  output logic [4:0]            freqCode,
  output logic                  spreadEn,
  output logic                  outTristate
);

  logic [1:0] lineClean;
  logic       sclF, sdaF;
  logic [7:0] rxByte;
  logic       txBit;
  strobe_t    stb;
  busState_t  busState;

  smb_line_filter #(.LINES(2)) uFilt (
    .clk      (clk),
    .rstN     (rstN),
    .rawIn    ({sclIn, sdaIn}),
    .cleanOut (lineClean)
  );

  assign sclF = lineClean[1];
  assign sdaF = lineClean[0];

  smb_cfg_ctrl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (sclF),
    .sdaF     (sdaF),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .stb      (stb),
    .sdaOe    (sdaOe),
    .busState (busState)
  );

  smb_cfg_dpath #(
    .NUM_REGS  (NUM_REGS),
    .REG0_INIT (REG0_INIT),
    .REGN_INIT (REGN_INIT),
    .RSVD_VAL  (RSVD_VAL)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .sdaF   (sdaF),
    .stb    (stb),
    .rxByte (rxByte),
    .txBit  (txBit),
    .cfgBus (cfgBus)
  );

  assign freqFromReg = cfgBus[3];
  assign freqCode    = {cfgBus[2], cfgBus[7:4]};
  assign spreadEn    = cfgBus[1];
  assign outTristate = cfgBus[0];

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclF,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] cfgBus,
  input logic                  wrEn,
  input logic                  loadTx,
  input logic [IDX_W-1:0]      ldIdx,
  input busState_t             busState
);

  logic [NUM_REGS*8-1:0] initImage;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) initImage[8*i +: 8] = (i == 0) ? REG0_INIT : REGN_INIT;
  end

  // R5: the first cycle out of reset shows the default image
  a_r5_reset_image: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> cfgBus == initImage);

  // R3: the registers change only after a datapath write strobe
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(cfgBus));

  // R2: a write is issued only at the end of a received byte, with SCL low
  a_r2_write_on_byte_end: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (busState == ST_RECV) && !sclF);

  // R4: the first byte loaded after the read address is the count
  a_r4_count_first: assert property (@(posedge clk) disable iff (!rstN)
    (loadTx && busState == ST_ACKW) |-> ldIdx == '0);

  // R4: the slave moves SDA only while SCL is low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclF);

  // R6: an idle slave writes nothing, loads nothing and drives nothing
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !wrEn && !loadTx && !sdaOe);

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
  .NUM_REGS  (NUM_REGS),
  .REG0_INIT (REG0_INIT),
  .REGN_INIT (REGN_INIT)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sclF     (sclF),
  .sdaOe    (sdaOe),
  .cfgBus   (cfgBus),
  .wrEn     (stb.wrEn),
  .loadTx   (stb.loadTx),
  .ldIdx    (stb.idx),
  .busState (busState)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;

  localparam int NREG = 6;
  localparam int Q    = 10;

  // [55:48] number of data bytes, [47:40] first data byte ... [7:0] sixth
  localparam logic [55:0] VEC [6] = '{
    {8'd6, 48'h5B_12_34_56_78_9A},
    {8'd2, 48'hC0_3C_00_00_00_00},
    {8'd0, 48'hFF_FF_FF_FF_FF_FF},
    {8'd6, 48'h00_FF_00_FF_00_FF},
    {8'd1, 48'hA5_00_00_00_00_00},
    {8'd5, 48'h01_02_04_08_10_77}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclH = 1'b1;
  logic        sdaH = 1'b1;
  logic        sdaLine;
  logic        sdaOe;
  logic [47:0] cfgBus;
  logic        freqFromReg;
  logic [4:0]  freqCode;
  logic        spreadEn;
  logic        outTristate;

  int   nChk = 0;
  int   nFail = 0;
  bit   finished = 0;
  logic [7:0] expReg [NREG];

  always #2.5 clk = ~clk;

  assign sdaLine = sdaH & ~sdaOe;

  smb_cfg_slave u0 (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclH),
    .sdaIn       (sdaLine),
    .sdaOe       (sdaOe),
    .cfgBus      (cfgBus),
    .freqFromReg (freqFromReg),
    .freqCode    (freqCode),
    .spreadEn    (spreadEn),
    .outTristate (outTristate)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] expFlat();
    logic [47:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = expReg[i];
    return f;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NREG; i++) expReg[i] = (i == 0) ? 8'h00 : 8'hFF;
  endtask

  task automatic busStart();
    sdaH = 1'b1; sclH = 1'b1; cyc(Q);
    sdaH = 1'b0; cyc(Q);
    sclH = 1'b0; cyc(2);
  endtask

  task automatic busStop();
    sdaH = 1'b0; cyc(Q);
    sclH = 1'b1; cyc(Q);
    sdaH = 1'b1; cyc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaH = b[i]; cyc(Q);
      sclH = 1'b1; cyc(Q / 2);
      if (glitch && i == 4) begin
        sdaH = ~b[i]; cyc(1);
        sdaH = b[i];
      end
      cyc(Q / 2);
      sclH = 1'b0; cyc(2);
    end
    sdaH = 1'b1; cyc(Q);
    sclH = 1'b1; cyc(Q / 2);
    acked = !sdaLine;
    cyc(Q / 2);
    sclH = 1'b0; cyc(2);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaH = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(Q);
      sclH = 1'b1; cyc(Q / 2);
      b[i] = sdaLine;
      cyc(Q / 2);
      sclH = 1'b0; cyc(2);
    end
    sdaH = ackIt ? 1'b0 : 1'b1; cyc(Q);
    sclH = 1'b1; cyc(Q);
    sclH = 1'b0; cyc(2);
    sdaH = 1'b1;
  endtask

  task automatic doWrite(input int n, input logic [55:0] d, input bit glitch, input string tag);
    bit a;
    busStart();
    sendByte(8'hD2, 1'b0, a); chk("R1 write address ack", 48'(a), 48'd1);
    sendByte(8'h9C, 1'b0, a); chk("R2 command byte ack", 48'(a), 48'd1);
    sendByte(8'h03, 1'b0, a); chk("R2 count byte ack", 48'(a), 48'd1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[55 - 8*i -: 8], glitch, a);
      chk(tag, 48'(a), 48'd1);
      if (i < NREG) expReg[i] = d[55 - 8*i -: 8];
    end
    busStop();
    chk(tag, cfgBus, expFlat());
  endtask

  task automatic doRead(input int n);
    bit a;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, 1'b0, a); chk("R1 read address ack", 48'(a), 48'd1);
    recvByte(n != 0, b); chk("R4 byte count", 48'(b), 48'd6);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      if (i < NREG) chk("R4 read data", 48'(b), 48'(expReg[i]));
      else          chk("R7 reserved read", 48'(b), 48'h06);
    end
    busStop();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    bit a;
    modelReset();
    cyc(4);
    chk("R5 image during reset", cfgBus, expFlat());
    rstN = 1'b1;
    cyc(4);
    chk("R5 defaults after reset", cfgBus, expFlat());
    chk("R8 decode at reset", 48'({freqFromReg, freqCode, spreadEn, outTristate}), 48'h0);
    doRead(6);

    // table walk: write (possibly early stop), then read everything back
    for (int v = 0; v < 6; v++) begin
      doWrite(int'(VEC[v][55:48]), {VEC[v][47:0], 8'h00}, 1'b0, "R2 R3 vector write");
      doRead(6);
    end

    // R6: foreign addresses
    busStart();
    sendByte(8'hA0, 1'b0, a); chk("R6 foreign address nack", 48'(a), 48'd0);
    busStop();
    busStart();
    sendByte(8'hD6, 1'b0, a); chk("R6 near address nack", 48'(a), 48'd0);
    busStop();
    chk("R6 registers unchanged", cfgBus, expFlat());

    // R7: seventh data byte and reading past the last register
    doWrite(7, 56'h11_22_33_44_55_66_EE, 1'b0, "R7 extra data byte");
    doRead(7);

    // R4: host NACK after the first register, then after the count only
    doRead(1);
    doRead(0);

    // R9: one-cycle SDA pulses during SCL high in every data byte
    doWrite(6, 56'hDE_AD_BE_EF_01_23_00, 1'b1, "R9 glitch write");
    doRead(6);

    // R8 and R10: register 0 decode and bus placement
    doWrite(1, 56'h5B_00_00_00_00_00_00, 1'b0, "R8 decode write");
    chk("R8 decode 0x5B", 48'({freqFromReg, freqCode, spreadEn, outTristate}), 48'({1'b1, 5'b00101, 1'b1, 1'b1}));
    chk("R10 register 0 low byte", 48'(cfgBus[7:0]), 48'h5B);
    chk("R10 register 5 top byte", 48'(cfgBus[47:40]), 48'(expReg[5]));
    doWrite(1, 56'h84_00_00_00_00_00_00, 1'b0, "R8 decode write");
    chk("R8 decode 0x84", 48'({freqFromReg, freqCode, spreadEn, outTristate}), 48'({1'b0, 5'b11000, 1'b0, 1'b0}));

    // R5: reset in mid-run restores defaults
    rstN = 1'b0; cyc(3);
    rstN = 1'b1; cyc(3);
    modelReset();
    chk("R5 defaults after second reset", cfgBus, expFlat());
    doRead(6);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

endmodule